// File: doc/BRIEF.md
# Flash Read Timing Calibration Engine

This engine finds a safe read-sampling delay for a serial flash controller at each clock divider it is allowed to use. When started, it asks the controller for one test block using the slowest, most conservative read setup and stores the result on chip as the golden copy. It then counts the words that are neither all zeros nor all ones. If there are too few, the test is not meaningful: the engine stops there and keeps the slow setting.

With a usable golden copy, the engine goes through the dividers from slowest to fastest. It skips any divider whose clock would reach the frequency cap. For each divider it tries up to twelve sampling-delay candidates in turn. Each candidate must reproduce the golden block on every one of several repeated reads. Once three candidates in a row pass, the engine keeps the middle one in that divider's nibble of the delay register and moves on to the next divider. At the end it selects the fastest divider that found a setting. A bus error from the read port ends the run at once with its own status.

Top module: `flash_rdcal`

## Requirements
- R1: After reset, `cal_done`, `blk_req`, `blk_safe`, `clk_div` and `dly_reg` are all zero.
- R2: After `cal_start`, the first block read is issued with `blk_safe`=1 and `clk_div`=0. Divider code 0 means the slowest safe clock, and codes 1..NDIV mean HCLK divided by that code.
- R3: The golden block is usable only when at least MIN_VARIED of its words are neither 0x00000000 nor 0xFFFFFFFF. Otherwise the run ends with status 1, `clk_div`=0 and `dly_reg`=0.
- R4: Dividers are tried from NDIV down to 1. A divider d is skipped when floor(HCLK_HZ/d) >= `freq_cap`, and the nibble of a skipped divider stays 0.
- R5: Candidates 0..11 are tried in increasing order. Candidate i is written as nibble value (i/2), plus 8 when i is even, into `dly_reg` bits [4*(d-1)+3 : 4*(d-1)]. No other nibble changes.
- R6: A candidate passes only when NREADS block reads in a row all equal the golden copy. A single mismatching word fails the candidate.
- R7: When the third candidate in a row passes, candidate i-1 is written and the divider's sweep ends. A failure clears the run of passes. If all twelve candidates are used up, the nibble is left at the code of candidate 11 (value 5).
- R8: The run ends with status 0, and `clk_div` set to the smallest divider that found a setting.
- R9: If no divider found a setting, the run ends with status 2 and `clk_div`=0.
- R10: `blk_err` during a block read ends the run with status 3 and `clk_div`=0, even when it comes in the same cycle as the block's last word.
- R11: `cal_done` and `blk_req` are each high for exactly one cycle at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cal_start | input | 1 | Starts a calibration run when idle |
| cal_done | output | 1 | One-cycle pulse when the run ends |
| cal_status | output | 2 | 0 ok, 1 test data too uniform, 2 no divider fits, 3 bus error |
| freq_cap | input | 32 | Upper frequency limit in Hz; a divider is used only below it |
| blk_req | output | 1 | One-cycle request for one test-block read |
| blk_safe | output | 1 | High while the golden block is read, selecting the conservative read mode |
| blk_vld | input | 1 | Read word valid |
| blk_data | input | 32 | Read word |
| blk_err | input | 1 | Bus error on the read port |
| clk_div | output | 3 | Divider code in use (0 = slowest safe) |
| dly_reg | output | 20 | Sampling-delay register, one 4-bit nibble per divider |

## Verification
Two functions can act in the same cycle: a bus error can arrive with the last word of a compare read, in the cycle that would otherwise complete that read and, with a mismatching word, fail the candidate. The bench makes this happen by raising `blk_err` together with the final `blk_vld` of a corrupted block. The outcome is correct only if status 3 is reported, not a verify failure or a move to the next candidate. Further runs use random delay windows and frequency caps, a candidate that fails only on its last repeat, and golden blocks one word either side of the usability threshold. Every result is compared with a model of the sweep kept in the bench.

// File: rtl/flash_rdcal.sv
module flash_rdcal #(
  parameter int NDIV       = 5,
  parameter int WORDS      = 128,
  parameter int NREADS     = 10,
  parameter int MIN_VARIED = 64,
  parameter int HCLK_HZ    = 200_000_000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cal_start,
  output logic            cal_done,
  output logic [1:0]      cal_status,
  input  logic [31:0]     freq_cap,
  output logic            blk_req,
  output logic            blk_safe,
  input  logic            blk_vld,
  input  logic [31:0]     blk_data,
  input  logic            blk_err,
  output logic [2:0]      clk_div,
  output logic [4*NDIV-1:0] dly_reg
);
  localparam int AW = $clog2(WORDS);
  localparam int CW = $clog2(WORDS + 1);
  localparam int RW = $clog2(NREADS);
  localparam logic [3:0] LAST_CAND = 4'd11;

  typedef enum logic [2:0] {S_IDLE, S_REQ, S_RECV, S_EVAL, S_NEXTD} state_t;
  state_t st;

  logic [31:0]   gold [WORDS];
  logic [AW-1:0] widx;
  logic [CW-1:0] vcnt;
  logic [RW-1:0] rdn;
  logic [3:0]    cand;
  logic [1:0]    pcnt;
  logic [2:0]    d, best;
  logic          capt, mism;
  logic [34:0]   need;
  logic          skip, varied;

  function automatic logic [3:0] enc(input logic [3:0] c);
    return {~c[0], c[3:1]};
  endfunction

  assign need     = 35'(freq_cap) * 35'(d);
  assign skip     = 35'(HCLK_HZ) >= need;
  assign varied   = (blk_data != 32'h0) && (blk_data != 32'hFFFF_FFFF);
  assign blk_req  = (st == S_REQ);
  assign blk_safe = capt;

  always_ff @(posedge clk) begin
    if (st == S_RECV && blk_vld && capt) gold[widx] <= blk_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cal_done <= 1'b0; cal_status <= 2'd0; clk_div <= 3'd0;
      dly_reg <= '0; widx <= '0; vcnt <= '0; rdn <= '0; cand <= '0;
      pcnt <= '0; d <= '0; best <= '0; capt <= 1'b0; mism <= 1'b0;
    end else begin
      cal_done <= 1'b0;
      case (st)
        S_IDLE: if (cal_start) begin
          dly_reg <= '0; clk_div <= 3'd0; best <= 3'd0; vcnt <= '0;
          capt <= 1'b1; d <= 3'(NDIV); st <= S_REQ;
        end
        S_REQ: begin
          widx <= '0; mism <= 1'b0; st <= S_RECV;
        end
        S_RECV: begin
          if (blk_err) begin
            cal_status <= 2'd3; clk_div <= 3'd0; capt <= 1'b0;
            cal_done <= 1'b1; st <= S_IDLE;
          end else if (blk_vld) begin
            if (capt) vcnt <= vcnt + CW'(varied);
            else if (blk_data != gold[widx]) mism <= 1'b1;
            widx <= widx + 1'b1;
            if (widx == AW'(WORDS - 1)) st <= S_EVAL;
          end
        end
        S_EVAL: begin
          if (capt) begin
            capt <= 1'b0;
            if (vcnt >= CW'(MIN_VARIED)) st <= S_NEXTD;
            else begin
              cal_status <= 2'd1; cal_done <= 1'b1; st <= S_IDLE;
            end
          end else if (!mism && rdn != RW'(NREADS - 1)) begin
            rdn <= rdn + 1'b1; st <= S_REQ;
          end else if (!mism && pcnt == 2'd2) begin
            dly_reg[{d - 3'd1, 2'b00} +: 4] <= enc(cand - 4'd1);
            best <= d; d <= d - 3'd1; st <= S_NEXTD;
          end else begin
            pcnt <= mism ? 2'd0 : pcnt + 2'd1;
            if (cand == LAST_CAND) begin
              d <= d - 3'd1; st <= S_NEXTD;
            end else begin
              cand <= cand + 4'd1; rdn <= '0;
              dly_reg[{d - 3'd1, 2'b00} +: 4] <= enc(cand + 4'd1);
              st <= S_REQ;
            end
          end
        end
        S_NEXTD: begin
          if (d == 3'd0) begin
            clk_div <= best; cal_status <= (best != 3'd0) ? 2'd0 : 2'd2;
            cal_done <= 1'b1; st <= S_IDLE;
          end else if (skip) d <= d - 3'd1;
          else begin
            clk_div <= d; cand <= '0; rdn <= '0; pcnt <= '0;
            dly_reg[{d - 3'd1, 2'b00} +: 4] <= enc(4'd0);
            st <= S_REQ;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/flash_rdcal_chk.sv
module flash_rdcal_chk #(
  parameter int NDIV = 5
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cal_done,
  input logic [1:0] cal_status,
  input logic       blk_req,
  input logic       blk_safe,
  input logic [2:0] clk_div
);
  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cal_done |=> !cal_done);
  // R11
  req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blk_req |=> !blk_req);
  // R2
  safe_slow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blk_safe |-> clk_div == 3'd0);
  // R9
  fail_slow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_done && cal_status != 2'd0) |-> clk_div == 3'd0);
  // R8
  ok_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_done && cal_status == 2'd0) |-> clk_div != 3'd0);
  // R4
  div_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    32'(clk_div) <= NDIV);
endmodule

bind flash_rdcal flash_rdcal_chk #(.NDIV(NDIV)) u_chk (
  .clk(clk), .rst_n(rst_n), .cal_done(cal_done), .cal_status(cal_status),
  .blk_req(blk_req), .blk_safe(blk_safe), .clk_div(clk_div));

// File: tb/flash_rdcal_bench.sv
module flash_rdcal_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NDIV = 5, WORDS = 16, NREADS = 10, MIN_VARIED = 8;
  localparam int HCLK_HZ = 200_000_000;

  logic clk = 1'b0, rst_n = 1'b0, cal_start = 1'b0;
  logic cal_done, blk_req, blk_safe;
  logic [1:0] cal_status;
  logic [31:0] freq_cap = 32'd0, blk_data = 32'd0;
  logic blk_vld = 1'b0, blk_err = 1'b0;
  logic [2:0] clk_div;
  logic [4*NDIV-1:0] dly_reg;

  flash_rdcal #(.NDIV(NDIV), .WORDS(WORDS), .NREADS(NREADS),
                .MIN_VARIED(MIN_VARIED), .HCLK_HZ(HCLK_HZ)) u_flash_rdcal (
    .clk(clk), .rst_n(rst_n), .cal_start(cal_start), .cal_done(cal_done),
    .cal_status(cal_status), .freq_cap(freq_cap), .blk_req(blk_req),
    .blk_safe(blk_safe), .blk_vld(blk_vld), .blk_data(blk_data),
    .blk_err(blk_err), .clk_div(clk_div), .dly_reg(dly_reg));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0, cycles = 0;
  int lo[NDIV+1], hi[NDIV+1];
  int fl_d, fl_i, err_req, reqn, last_dv, rc;
  logic [3:0] last_nb;
  logic [31:0] pat[WORDS];

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic bit pass_c(input int d, input int i);
    return i >= lo[d] && i <= hi[d] && !(d == fl_d && i == fl_i);
  endfunction

  function automatic logic [3:0] code_of(input int i);
    return 4'((i / 2) | ((i % 2 == 0) ? 8 : 0));
  endfunction

  task automatic model(input logic [31:0] cap, output logic [1:0] est,
                       output logic [2:0] ediv, output logic [4*NDIV-1:0] etmg);
    int nv, best;
    nv = 0; best = 0; etmg = '0;
    for (int k = 0; k < WORDS; k++)
      if (pat[k] != 32'h0 && pat[k] != 32'hFFFF_FFFF) nv++;
    if (err_req > 0) begin est = 2'd3; ediv = 3'd0; return; end
    if (nv < MIN_VARIED) begin est = 2'd1; ediv = 3'd0; return; end
    for (int d = NDIV; d >= 1; d--) begin
      int run, pick;
      if (HCLK_HZ / d >= cap) continue;
      run = 0; pick = -1;
      for (int i = 0; i < 12 && pick < 0; i++) begin
        run = pass_c(d, i) ? run + 1 : 0;
        if (run == 3) pick = i - 1;
      end
      etmg[4*(d-1) +: 4] = (pick >= 0) ? code_of(pick) : code_of(11);
      if (pick >= 0) best = d;
    end
    est = (best != 0) ? 2'd0 : 2'd2;
    ediv = 3'(best);
  endtask

  task automatic serve_read();
    bit g, ok, ef;
    int dv, ci;
    logic [3:0] nb;
    reqn++;
    g = blk_safe; dv = int'(clk_div); ok = 1'b1;
    if (reqn == 1) chk(g && dv == 0, "R2 golden read in safe mode", {g, clk_div}, 4'h8);
    if (!g) begin
      nb = dly_reg[4*(dv-1) +: 4];
      ci = 2 * int'(nb[2:0]) + (nb[3] ? 0 : 1);
      if (dv == last_dv && nb == last_nb) rc++;
      else begin rc = 1; last_dv = dv; last_nb = nb; end
      ok = ci >= lo[dv] && ci <= hi[dv] && !(dv == fl_d && ci == fl_i && rc == NREADS);
    end
    ef = (reqn == err_req);
    if (ef) ok = 1'b0;
    for (int k = 0; k < WORDS; k++) begin
      @(negedge clk);
      blk_vld = 1'b1;
      blk_data = (k == 3 && !ok) ? pat[k] ^ 32'h0000_0100 : pat[k];
      blk_err = ef && (k == WORDS - 1);
    end
    @(negedge clk);
    blk_vld = 1'b0; blk_err = 1'b0;
  endtask

  task automatic run_cal(input string name, input logic [31:0] cap);
    logic [1:0] est; logic [2:0] ediv; logic [4*NDIV-1:0] etmg;
    model(cap, est, ediv, etmg);
    freq_cap = cap; reqn = 0; last_dv = -1; last_nb = 4'h0; rc = 0;
    @(negedge clk); cal_start = 1'b1;
    @(negedge clk); cal_start = 1'b0;
    forever begin
      if (cal_done) break;
      if (blk_req) serve_read();
      else @(negedge clk);
    end
    chk(cal_status == est, {name, " status"}, cal_status, est);
    chk(clk_div == ediv, {name, " divider"}, clk_div, ediv);
    if (err_req == 0) chk(dly_reg == etmg, {name, " delay register"}, dly_reg, etmg);
    @(negedge clk);
    chk(!cal_done, "R11 done lasts one cycle", cal_done, 0);
  endtask

  task automatic set_pat(input int nv);
    for (int k = 0; k < WORDS; k++)
      pat[k] = (k < nv) ? ($urandom() | 32'h1) & 32'h7FFF_FFFF
                        : ((k % 2 == 0) ? 32'h0 : 32'hFFFF_FFFF);
  endtask

  task automatic win_all(input int l, input int h);
    for (int d = 1; d <= NDIV; d++) begin lo[d] = l; hi[d] = h; end
    fl_d = 0; fl_i = -1; err_req = 0;
  endtask

  initial begin
    while (cycles < 190000) begin @(posedge clk); cycles++; end
    fails++;
    $display("FAIL watchdog expired actual=%0d expected<190000", cycles);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk({cal_done, blk_req, blk_safe} == 3'b000, "R1 reset handshake", {cal_done, blk_req, blk_safe}, 0);
    chk(clk_div == 3'd0, "R1 reset divider", clk_div, 0);
    chk(dly_reg == '0, "R1 reset delay register", dly_reg, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!cal_done && !blk_req, "R1 idle after reset", {cal_done, blk_req}, 0);

    set_pat(WORDS); win_all(2, 9);
    run_cal("R5/R7/R8 all dividers usable", 32'd250_000_000);
    set_pat(WORDS); win_all(0, 11);
    run_cal("R5/R7 window from candidate 0", 32'd250_000_000);
    set_pat(12); win_all(3, 8);
    run_cal("R4 fast dividers skipped", 32'd90_000_000);
    set_pat(WORDS); win_all(1, 10); lo[1] = 2; hi[1] = 6; fl_d = 1; fl_i = 3;
    run_cal("R6 failure on last repeat only", 32'd250_000_000);
    set_pat(WORDS); win_all(4, 7); lo[1] = 5; hi[1] = 6; lo[3] = 0; hi[3] = 1;
    run_cal("R7 narrow windows exhaust", 32'd250_000_000);
    set_pat(WORDS); win_all(15, 15);
    run_cal("R9 no divider fits", 32'd250_000_000);
    set_pat(MIN_VARIED - 1); win_all(0, 11);
    run_cal("R3 golden one word short", 32'd250_000_000);
    set_pat(MIN_VARIED); win_all(0, 11);
    run_cal("R3 golden exactly at threshold", 32'd250_000_000);
    set_pat(WORDS); win_all(0, 11); err_req = 4;
    run_cal("R10 bus error with last mismatching word", 32'd250_000_000);
    set_pat(WORDS); win_all(0, 11); err_req = 1;
    run_cal("R10 bus error during golden capture", 32'd250_000_000);

    for (int r = 0; r < 4; r++) begin
      logic [31:0] caps[4];
      caps = '{32'd50_000_000, 32'd70_000_000, 32'd110_000_000, 32'd250_000_000};
      set_pat(WORDS); win_all(15, 15);
      for (int d = 1; d <= NDIV; d++) begin
        if ($urandom() % 4 != 0) begin
          lo[d] = int'($urandom() % 12);
          hi[d] = lo[d] + int'($urandom() % (12 - lo[d]));
        end
      end
      run_cal("R4/R6/R7/R8 random windows", caps[$urandom() % 4]);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule